// File: doc/BRIEF.md
# I2C Bus Condition Monitor with Line Recovery

This block watches the two wires of an I2C bus and tells the other agents on the chip what the bus is doing. Both lines are first passed through multi-flop synchronizers. The block then reports every START, repeated START and STOP condition as a one-cycle pulse, and it keeps a bus-busy flag. This flag sets on a START and clears only on a STOP. A STOP that directly follows a START or a repeated START, with no clock activity in between, is also reported as an empty message. After that, monitoring continues as usual.

The block can also free a hung bus. A recovery request starts the recovery, and so does an SDA line that stays low for a programmable number of cycles while the recovery engine is at rest. The engine toggles SCL through its open-drain pull output, checking SDA at the end of every high phase. As soon as SDA reads high, it stops clocking, drives a clean STOP and pulses a completion flag. If SDA is still low after the maximum number of pulses, the engine releases both lines and raises a reset request. It does the same if SCL stays low for the programmable time while the block is not pulling it. The reset request stays high until the next recovery request.

Top module: `i2c_line_guard`

## Requirements
- R1: A falling SDA while SCL is high, seen when the bus is not busy, gives a one-cycle `start_pulse` after the third rising clock edge that follows the raw input change, and sets `bus_busy`.
- R2: A rising SDA while SCL is high gives a one-cycle `stop_pulse` and clears `bus_busy`.
- R3: A START seen while `bus_busy` is high gives `rstart_pulse` and no `start_pulse`, and `bus_busy` stays high.
- R4: Both lines being high in the middle of a transfer, with no STOP, leaves `bus_busy` high.
- R5: A STOP with no SCL falling edge since the last START or repeated START gives `void_pulse` in the same cycle as `stop_pulse`. The next START is then reported normally.
- R6: During recovery, SCL is pulled low for HALF_CYCLES cycles and then released for HALF_CYCLES cycles, and SDA is sampled at the end of each released phase. Clocking stops at the first high sample, and at most MAX_PULSES low phases are made.
- R7: Once SDA samples high, the block pulls SDA low while SCL is pulled low. It then releases SCL, then releases SDA, which forms a STOP on the bus, and then pulses `clear_done` for one cycle.
- R8: If SDA is still low at the sample after MAX_PULSES pulses, both pull outputs are released and `reset_request` is raised. It stays high until the next `clear_req`.
- R9: SCL low for STUCK_CYCLES consecutive cycles while the block is not pulling it raises `reset_request`.
- R10: SDA low for STUCK_CYCLES consecutive cycles while the recovery engine is at rest starts the recovery sequence without any request.
- R11: After reset, every pulse output, `bus_busy`, `reset_request` and both pull outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level read from the bus |
| sda_in | input | 1 | Raw SDA level read from the bus |
| clear_req | input | 1 | Request to run the recovery sequence |
| scl_pull_low | output | 1 | Pulls SCL low when high (open-drain enable) |
| sda_pull_low | output | 1 | Pulls SDA low when high (open-drain enable) |
| start_pulse | output | 1 | START seen on an idle bus |
| rstart_pulse | output | 1 | Repeated START seen on a busy bus |
| stop_pulse | output | 1 | STOP seen |
| void_pulse | output | 1 | STOP that followed a START with no clocking |
| bus_busy | output | 1 | Bus is owned between a START and a STOP |
| clear_done | output | 1 | Recovery finished with a STOP on the bus |
| reset_request | output | 1 | Recovery failed or SCL is stuck low |

## Verification
The assertions assume that the raw lines behave like an open-drain bus. The SCL and SDA levels the block reads are the wired-AND of the external drivers and its own pull outputs, so a line it pulls low reads low two flops later. They also assume that no other agent changes SDA and SCL in the same clock cycle. The bench models each line as an external level ANDed with the inverted pull output. It changes only one line per falling clock edge and holds each level for several cycles, so the synchronizers always resolve the order of edges the way the stimulus intends.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;

   typedef enum logic [3:0] {
      RC_IDLE,
      RC_SAMPLE,
      RC_LOW,
      RC_STP_A,
      RC_STP_B,
      RC_STP_C,
      RC_STP_D,
      RC_DONE,
      RC_FAIL
   } rc_state_t;

   typedef struct packed {
      logic start;
      logic rstart;
      logic stop;
      logic void_msg;
   } bus_evt_t;

   localparam int LINE_SDA = 0;
   localparam int LINE_SCL = 1;

endpackage

// File: rtl/i2c_guard_sync.sv
module i2c_guard_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] d,
   output logic [LINES-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_guard_sync: STAGES must be at least 2");
   end

   for (genvar ln = 0; ln < LINES; ln++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], d[ln]};
      end
      assign q[ln] = chain[STAGES-1];
   end

endmodule

// File: rtl/i2c_guard_detect.sv
module i2c_guard_detect
   import i2c_guard_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt,
   output logic     busy
);

   logic scl_q, sda_q, armed;
   logic both_hi, start_c, stop_c, scl_fall;

   always_comb begin
      both_hi  = scl_q & scl_s;
      start_c  = both_hi & sda_q & ~sda_s;
      stop_c   = both_hi & ~sda_q & sda_s;
      scl_fall = scl_q & ~scl_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
         busy  <= 1'b0;
         armed <= 1'b0;
         evt   <= '0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         evt   <= '{start: start_c & ~busy, rstart: start_c & busy,
                    stop: stop_c, void_msg: stop_c & armed};
         if (start_c)     busy <= 1'b1;
         else if (stop_c) busy <= 1'b0;
         if (start_c)                  armed <= 1'b1;
         else if (stop_c || scl_fall)  armed <= 1'b0;
      end
   end

endmodule

// File: rtl/i2c_guard_recover.sv
module i2c_guard_recover
   import i2c_guard_pkg::*;
#(
   parameter int HALF_CYCLES  = 250,
   parameter int MAX_PULSES   = 9,
   parameter int STUCK_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   input  logic clear_req,
   output logic scl_pull,
   output logic sda_pull,
   output logic done,
   output logic rst_req
);

   localparam int TW = $clog2(HALF_CYCLES + 1);
   localparam int PW = $clog2(MAX_PULSES + 1);
   localparam int SW = $clog2(STUCK_CYCLES + 1);

   if (HALF_CYCLES < 2) begin : g_bad_half
      $error("i2c_guard_recover: HALF_CYCLES must be at least 2");
   end
   if (MAX_PULSES < 1) begin : g_bad_pulses
      $error("i2c_guard_recover: MAX_PULSES must be at least 1");
   end
   if (STUCK_CYCLES < 4) begin : g_bad_stuck
      $error("i2c_guard_recover: STUCK_CYCLES must be at least 4");
   end

   rc_state_t      st, st_nx;
   logic [TW-1:0]  tmr;
   logic [PW-1:0]  pulses;
   logic [SW-1:0]  scl_low_cnt, sda_low_cnt;
   logic           phase_end, scl_stuck, sda_stuck;

   always_comb begin
      phase_end = (tmr == TW'(HALF_CYCLES - 1));
      scl_stuck = (scl_low_cnt == SW'(STUCK_CYCLES));
      sda_stuck = (sda_low_cnt == SW'(STUCK_CYCLES));
      scl_pull  = (st == RC_LOW) || (st == RC_STP_A) || (st == RC_STP_B);
      sda_pull  = (st == RC_STP_B) || (st == RC_STP_C);
      done      = (st == RC_DONE);
      rst_req   = (st == RC_FAIL);
   end

   always_comb begin
      st_nx = st;
      case (st)
         RC_IDLE:   if (clear_req || sda_stuck) st_nx = RC_SAMPLE;
         RC_SAMPLE: if (phase_end) begin
                       if (sda_s)                            st_nx = RC_STP_A;
                       else if (pulses >= PW'(MAX_PULSES))   st_nx = RC_FAIL;
                       else                                  st_nx = RC_LOW;
                    end
         RC_LOW:    if (phase_end) st_nx = RC_SAMPLE;
         RC_STP_A:  if (phase_end) st_nx = RC_STP_B;
         RC_STP_B:  if (phase_end) st_nx = RC_STP_C;
         RC_STP_C:  if (phase_end) st_nx = RC_STP_D;
         RC_STP_D:  if (phase_end) st_nx = RC_DONE;
         RC_DONE:   st_nx = RC_IDLE;
         RC_FAIL:   if (clear_req) st_nx = RC_SAMPLE;
         default:   st_nx = RC_IDLE;
      endcase
      if (scl_stuck && st != RC_FAIL) st_nx = RC_FAIL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= RC_IDLE;
         tmr         <= '0;
         pulses      <= '0;
         scl_low_cnt <= '0;
         sda_low_cnt <= '0;
      end else begin
         st <= st_nx;
         if (st_nx != st)     tmr <= '0;
         else if (!phase_end) tmr <= tmr + 1'b1;
         if (st == RC_IDLE || st == RC_FAIL)  pulses <= '0;
         else if (st == RC_LOW && phase_end)  pulses <= pulses + 1'b1;
         if (scl_s || scl_pull)  scl_low_cnt <= '0;
         else if (!scl_stuck)    scl_low_cnt <= scl_low_cnt + 1'b1;
         if (sda_s || st != RC_IDLE) sda_low_cnt <= '0;
         else if (!sda_stuck)        sda_low_cnt <= sda_low_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/i2c_line_guard.sv
module i2c_line_guard
   import i2c_guard_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int HALF_CYCLES  = 250,
   parameter int MAX_PULSES   = 9,
   parameter int STUCK_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic clear_req,
   output logic scl_pull_low,
   output logic sda_pull_low,
   output logic start_pulse,
   output logic rstart_pulse,
   output logic stop_pulse,
   output logic void_pulse,
   output logic bus_busy,
   output logic clear_done,
   output logic reset_request
);

   logic [1:0] raw_lines, sync_lines;
   bus_evt_t   evt;

   assign raw_lines[LINE_SCL] = scl_in;
   assign raw_lines[LINE_SDA] = sda_in;

   i2c_guard_sync #(.STAGES(SYNC_STAGES), .LINES(2)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
   );

   i2c_guard_detect detect_i (
      .clk(clk), .rst_n(rst_n),
      .scl_s(sync_lines[LINE_SCL]), .sda_s(sync_lines[LINE_SDA]),
      .evt(evt), .busy(bus_busy)
   );

   i2c_guard_recover #(
      .HALF_CYCLES(HALF_CYCLES), .MAX_PULSES(MAX_PULSES),
      .STUCK_CYCLES(STUCK_CYCLES)
   ) recover_i (
      .clk(clk), .rst_n(rst_n),
      .scl_s(sync_lines[LINE_SCL]), .sda_s(sync_lines[LINE_SDA]),
      .clear_req(clear_req),
      .scl_pull(scl_pull_low), .sda_pull(sda_pull_low),
      .done(clear_done), .rst_req(reset_request)
   );

   assign start_pulse  = evt.start;
   assign rstart_pulse = evt.rstart;
   assign stop_pulse   = evt.stop;
   assign void_pulse   = evt.void_msg;

endmodule

// File: rtl/i2c_line_guard_chk.sv
module i2c_line_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_pull_low,
   input logic sda_pull_low,
   input logic start_pulse,
   input logic rstart_pulse,
   input logic stop_pulse,
   input logic void_pulse,
   input logic bus_busy,
   input logic clear_done,
   input logic reset_request
);

   // R1: a fresh START always leaves the bus owned
   a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> bus_busy);

   // R3: a repeated START only happens on an owned bus, which stays owned
   a_r3_rstart_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rstart_pulse |-> ($past(bus_busy) && bus_busy));

   // R2, R4: the bus is released by a STOP and nothing else
   a_r4_idle_only_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_busy) |-> stop_pulse);

   // R5: an empty message is reported together with its STOP
   a_r5_void_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
      void_pulse |-> stop_pulse);

   // R1, R2, R3: at most one bus condition per cycle
   a_r2_single_condition: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_pulse, rstart_pulse, stop_pulse}));

   // R7: SDA is only pulled while SCL is already held low, so no false START
   a_r7_sda_pull_under_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_low) |-> scl_pull_low);

   // R7: completion is a single-cycle pulse with the bus released
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      clear_done |-> (!scl_pull_low && !sda_pull_low) ##1 !clear_done);

   // R8, R9: a reset request never keeps a line pulled
   a_r8_fail_releases: assert property (@(posedge clk) disable iff (!rst_n)
      reset_request |-> (!scl_pull_low && !sda_pull_low));

endmodule

bind i2c_line_guard i2c_line_guard_chk chk_i (
   .clk(clk), .rst_n(rst_n),
   .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
   .start_pulse(start_pulse), .rstart_pulse(rstart_pulse),
   .stop_pulse(stop_pulse), .void_pulse(void_pulse),
   .bus_busy(bus_busy), .clear_done(clear_done),
   .reset_request(reset_request)
);

// File: tb/i2c_line_guard_tb.sv
`timescale 1ns/1ps
module i2c_line_guard_tb_top;

   localparam int HALF  = 8;
   localparam int MAXP  = 9;
   localparam int STUCK = 40;
   localparam int BIT_H = 5;

   localparam int EV_START  = 0;
   localparam int EV_RSTART = 1;
   localparam int EV_STOP   = 2;
   localparam int EV_VOID   = 3;
   localparam int EV_DONE   = 4;
   localparam int EV_RR     = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_ext = 1'b1, sda_ext = 1'b1, clear_req = 1'b0;
   logic scl_in, sda_in;
   logic scl_pull_low, sda_pull_low, start_pulse, rstart_pulse, stop_pulse;
   logic void_pulse, bus_busy, clear_done, reset_request;

   int checks = 0;
   int errors = 0;
   int rises  = 0;
   int exp_q[$];
   logic rr_q = 1'b0;

   always #10 clk = ~clk;

   assign scl_in = scl_ext & ~scl_pull_low;
   assign sda_in = sda_ext & ~sda_pull_low;

   i2c_line_guard #(
      .SYNC_STAGES(2), .HALF_CYCLES(HALF), .MAX_PULSES(MAXP), .STUCK_CYCLES(STUCK)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .clear_req(clear_req), .scl_pull_low(scl_pull_low),
      .sda_pull_low(sda_pull_low), .start_pulse(start_pulse),
      .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse),
      .void_pulse(void_pulse), .bus_busy(bus_busy), .clear_done(clear_done),
      .reset_request(reset_request)
   );

   always @(posedge scl_in) rises++;

   function automatic string ev_req(int code);
      case (code)
         EV_START:  return "R1";
         EV_RSTART: return "R3";
         EV_STOP:   return "R2";
         EV_VOID:   return "R5";
         EV_DONE:   return "R7";
         default:   return "R8";
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   task automatic expect_ev(input int code);
      exp_q.push_back(code);
   endtask

   task automatic observe(input int code);
      checks++;
      if (exp_q.size() == 0) begin
         errors++;
         $display("FAIL %s: actual event %0d expected none", ev_req(code), code);
      end else begin
         int want = exp_q.pop_front();
         if (want != code) begin
            errors++;
            $display("FAIL %s: actual event %0d expected event %0d", ev_req(want), code, want);
         end
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (start_pulse)  observe(EV_START);
         if (rstart_pulse) observe(EV_RSTART);
         if (stop_pulse)   observe(EV_STOP);
         if (void_pulse)   observe(EV_VOID);
         if (clear_done)   observe(EV_DONE);
         if (reset_request && !rr_q) observe(EV_RR);
         rr_q = reset_request;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_sda(input logic v);
      @(negedge clk); sda_ext = v;
   endtask

   task automatic set_scl(input logic v);
      @(negedge clk); scl_ext = v;
   endtask

   task automatic send_bit(input logic v);
      set_scl(1'b0); idle(2); set_sda(v); idle(BIT_H);
      set_scl(1'b1); idle(BIT_H); set_scl(1'b0); idle(2);
   endtask

   task automatic pulse_clear;
      @(negedge clk); clear_req = 1'b1;
      @(negedge clk); clear_req = 1'b0;
   endtask

   task automatic wait_for(input int which, input int limit, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < limit && !seen; i++) begin
         @(negedge clk);
         if (which == 0 && clear_done)    seen = 1'b1;
         if (which == 1 && reset_request) seen = 1'b1;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      bit seen;
      idle(3);
      // R11: reset state
      check("R11 pulses idle", {start_pulse, rstart_pulse, stop_pulse, void_pulse, clear_done}, 0);
      check("R11 busy", bus_busy, 0);
      check("R11 reset_request", reset_request, 0);
      check("R11 pulls", {scl_pull_low, sda_pull_low}, 0);
      rst_n = 1'b1;
      idle(4);

      // R1: START latency and busy
      expect_ev(EV_START);
      set_sda(1'b0);
      idle(2);
      check("R1 no pulse before third edge", start_pulse, 0);
      idle(1);
      check("R1 pulse after third edge", start_pulse, 1);
      idle(1);
      check("R1 busy after START", bus_busy, 1);

      // R4: both lines high mid transfer
      send_bit(1'b1);
      send_bit(1'b0);
      set_sda(1'b1);
      set_scl(1'b1);
      idle(10);
      check("R4 busy with both lines high", bus_busy, 1);

      // R3: repeated START
      expect_ev(EV_RSTART);
      set_sda(1'b0);
      idle(6);
      check("R3 busy kept after repeated START", bus_busy, 1);
      send_bit(1'b1);
      send_bit(1'b0);

      // R2: STOP
      expect_ev(EV_STOP);
      set_sda(1'b0);
      set_scl(1'b1);
      idle(4);
      set_sda(1'b1);
      idle(6);
      check("R2 idle after STOP", bus_busy, 0);

      // R5: void message, then a normal START and a void after repeated START
      expect_ev(EV_START);
      set_sda(1'b0);
      idle(5);
      expect_ev(EV_STOP);
      expect_ev(EV_VOID);
      set_sda(1'b1);
      idle(6);
      check("R5 idle after void message", bus_busy, 0);
      expect_ev(EV_START);
      set_sda(1'b0);
      idle(5);
      send_bit(1'b1);
      set_scl(1'b1);
      idle(4);
      expect_ev(EV_RSTART);
      set_sda(1'b0);
      idle(5);
      expect_ev(EV_STOP);
      expect_ev(EV_VOID);
      set_sda(1'b1);
      idle(6);
      check("R5 idle after void repeated START", bus_busy, 0);

      // R6, R7: manual clear, SDA frees after third pulse
      expect_ev(EV_START);
      set_sda(1'b0);
      idle(4);
      rises = 0;
      expect_ev(EV_STOP);
      expect_ev(EV_DONE);
      pulse_clear();
      wait (rises == 3);
      @(negedge clk); sda_ext = 1'b1;
      wait_for(0, 2000, seen);
      check("R7 clear_done seen", int'(seen), 1);
      check("R6 SCL rises (3 pulses plus STOP)", rises, 4);
      idle(3);
      check("R7 bus idle after recovery STOP", bus_busy, 0);
      check("R7 lines released", {scl_pull_low, sda_pull_low}, 0);

      // R10, R8: SDA stuck for good, automatic start, failure
      expect_ev(EV_START);
      expect_ev(EV_RR);
      rises = 0;
      set_sda(1'b0);
      wait_for(1, 3000, seen);
      check("R8 reset_request after max pulses", int'(seen), 1);
      check("R10 automatic recovery made max pulses", rises, MAXP);
      idle(20);
      check("R8 reset_request held", reset_request, 1);
      expect_ev(EV_STOP);
      set_sda(1'b1);
      idle(6);
      expect_ev(EV_STOP);
      expect_ev(EV_DONE);
      pulse_clear();
      wait_for(0, 2000, seen);
      check("R8 recovery after release", int'(seen), 1);
      check("R8 reset_request cleared", reset_request, 0);

      // R9: SCL stuck low
      expect_ev(EV_RR);
      set_scl(1'b0);
      idle(STUCK + 10);
      check("R9 reset_request on stuck SCL", reset_request, 1);
      set_scl(1'b1);
      idle(6);
      expect_ev(EV_STOP);
      expect_ev(EV_DONE);
      pulse_clear();
      wait_for(0, 2000, seen);
      check("R9 recovery after SCL release", int'(seen), 1);
      check("R9 reset_request cleared", reset_request, 0);
      idle(10);

      check("R1 scoreboard drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule